// File: doc/BRIEF.md
# Store-Immediate Flag Predictor

This block predicts the N, Z and V condition-code bits that an undocumented store-immediate opcode leaves behind. When such an opcode is unprefixed, the three bits do not come from the stored value. They depend on which kind of instruction retired just before it, and each kind has its own rule that reads accumulator, result or address data. When the opcode carries a page prefix, the three bits take one fixed value.

A decoder upstream sorts each retiring instruction into a three-bit group code and pulses a retire strobe. On that strobe, the block records the group, the high byte of the 16-bit compare/add result and the byte-wise OR of the computed effective address. When the core later issues a store-immediate request, the block combines the recorded group with the live A and B accumulators, the low bytes of X and U, the selected register and the prefix bit. One cycle later it returns the full condition-code byte. In that byte only N, Z and V are new. Every other bit is the value of the condition-code input as sampled with the request.

Top module: `sti_flag_predict`

## Requirements
- R1: Group codes are 0 other, 1 compare/bit-test on A, 2 load of A or D, 3 8-bit arithmetic/logic on A, 4 unary op on A, 5 sign-extend (uses B), 6 16-bit compare/add, 7 address computation. After reset the recorded group is 0. Group 0 gives N=1, Z=0, V=0.
- R2: The recorded group, result byte and address byte change only on a cycle with the retire strobe high. A request in the same cycle as a retire uses the group recorded before that retire.
- R3: Group 1 gives N=0, Z=1, V=0.
- R4: Group 2 gives Z=1 exactly when A is 0x00, N equal to A bit 7, and V=0.
- R5: Group 3 gives Z=1 exactly when A is 0xFF, N=1 exactly when A bit 7 is 0, and V=0.
- R6: Groups 4 and 5 apply a shared rule to a byte R, with R being live A for group 4 and live B for group 5. The rule gives Z=1 when R is 0x01, N equal to bit 7 of R-1 (mod 256), and V=1 when R is 0x80.
- R7: Group 6 applies the R6 rule with R being the result high byte captured at retire. Group 7 applies it with R being the high byte of the address captured at retire ORed with its low byte.
- R8: The register select is 0 A, 1 B, 2 X/Y (16-bit), 3 U/S (16-bit). For an unprefixed select 2 with a non-zero X low byte, Z is forced to 0. The same holds for select 3 with a non-zero U low byte. In all other cases Z follows the group rule.
- R9: A prefixed request gives N=1, Z=0, V=0 whatever the recorded group.
- R10: The condition-code byte uses E bit 7, F bit 6, H bit 5, I bit 4, N bit 3, Z bit 2, V bit 1, C bit 0. Bits other than N, Z, V are copied from the condition-code input sampled with the request.
- R11: The condition-code output and the valid strobe are registered. Both are updated on the clock edge that samples a request, and the valid strobe is low on every cycle that does not follow a request. Reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_grp | input | 3 | Group code of the retiring instruction |
| alu_res_hi | input | 8 | High byte of the 16-bit compare/add result of the retiring instruction |
| ea_value | input | 16 | Effective address computed by the retiring instruction |
| acc_a | input | 8 | Live A accumulator |
| acc_b | input | 8 | Live B accumulator |
| x_low | input | 8 | Low byte of X |
| u_low | input | 8 | Low byte of U |
| sti_req | input | 1 | Store-immediate flag request |
| sti_sel | input | 2 | Register selected by the store |
| sti_prefixed | input | 1 | Store carried a page prefix |
| cc_in | input | 8 | Condition codes before the store |
| cc_out | output | 8 | Condition codes after the store |
| cc_vld | output | 1 | cc_out holds a fresh result |

## Verification
The hardest case to reach is a request that must see the old group while a new instruction retires in the same cycle. The bench drives both strobes in one cycle and computes the expected value from the older group. A second hard case is the pair of captured operands for groups 6 and 7. To show they are latched and not live, the bench changes the result and address inputs after the retire and before the request. The 16-bit forms are run against the same recorded group twice, once with a zero register low byte and once with a non-zero one, to show the Z override on its own.

// File: rtl/sti_pkg.sv
package sti_pkg;

   localparam int GRP_W = 3;
   localparam int SEL_W = 2;

   typedef enum logic [GRP_W-1:0] {
      GRP_OTHER = 3'd0,
      GRP_TESTA = 3'd1,
      GRP_LOADA = 3'd2,
      GRP_ALUA  = 3'd3,
      GRP_UNA   = 3'd4,
      GRP_SEXB  = 3'd5,
      GRP_CMP16 = 3'd6,
      GRP_ADDR  = 3'd7
   } grp_e;

   typedef enum logic [SEL_W-1:0] {
      SEL_A  = 2'd0,
      SEL_B  = 2'd1,
      SEL_XY = 2'd2,
      SEL_US = 2'd3
   } sel_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
   } nzv_t;

   localparam nzv_t NZV_FIXED = '{n: 1'b1, z: 1'b0, v: 1'b0};

endpackage

// File: rtl/sti_grp_track.sv
module sti_grp_track
   import sti_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  retire_vld,
   input  logic [GRP_W-1:0]      retire_grp,
   input  logic [DATA_W-1:0]     alu_res_hi,
   input  logic [2*DATA_W-1:0]   ea_value,
   output grp_e                  grp_q,
   output logic [DATA_W-1:0]     res_q,
   output logic [DATA_W-1:0]     addr_q
);

   localparam int ADDR_W = 2 * DATA_W;

   logic [DATA_W-1:0] addr_fold;

   assign addr_fold = ea_value[ADDR_W-1:DATA_W] | ea_value[DATA_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q  <= GRP_OTHER;
         res_q  <= '0;
         addr_q <= '0;
      end else if (retire_vld) begin
         grp_q  <= grp_e'(retire_grp);
         res_q  <= alu_res_hi;
         addr_q <= addr_fold;
      end
   end

   // R2: state moves only on a retire
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_vld |=> ($stable(grp_q) && $stable(res_q) && $stable(addr_q)));

   // R2: a retire records its group
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      retire_vld |=> (grp_q == grp_e'($past(retire_grp))));

endmodule

// File: rtl/sti_rule_eval.sv
module sti_rule_eval
   import sti_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  grp_e              grp,
   input  logic [DATA_W-1:0] acc_a,
   input  logic [DATA_W-1:0] acc_b,
   input  logic [DATA_W-1:0] res_hi,
   input  logic [DATA_W-1:0] addr_or,
   output nzv_t              nzv
);

   localparam int              MSB  = DATA_W - 1;
   localparam logic [MSB:0]    ONE  = DATA_W'(1);
   localparam logic [MSB:0]    SIGN = {1'b1, {(DATA_W-1){1'b0}}};
   localparam logic [MSB:0]    ALL1 = {DATA_W{1'b1}};

   function automatic nzv_t unit_rule(input logic [MSB:0] r);
      logic [MSB:0] dec;
      nzv_t         o;
      dec = r - ONE;
      o.n = dec[MSB];
      o.z = (r == ONE);
      o.v = (r == SIGN);
      return o;
   endfunction

   logic [MSB:0] shared_src;

   always_comb begin
      unique case (grp)
         GRP_SEXB:  shared_src = acc_b;
         GRP_CMP16: shared_src = res_hi;
         GRP_ADDR:  shared_src = addr_or;
         default:   shared_src = acc_a;
      endcase
   end

   always_comb begin
      unique case (grp)
         GRP_TESTA: nzv = '{n: 1'b0, z: 1'b1, v: 1'b0};
         GRP_LOADA: nzv = '{n: acc_a[MSB], z: (acc_a == '0), v: 1'b0};
         GRP_ALUA:  nzv = '{n: !acc_a[MSB], z: (acc_a == ALL1), v: 1'b0};
         GRP_UNA,
         GRP_SEXB,
         GRP_CMP16,
         GRP_ADDR:  nzv = unit_rule(shared_src);
         default:   nzv = NZV_FIXED;
      endcase
   end

endmodule

// File: rtl/sti_merge.sv
module sti_merge
   import sti_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CC_W    = 8,
   parameter int N_BIT   = 3,
   parameter int Z_BIT   = 2,
   parameter int V_BIT   = 1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [SEL_W-1:0]  sel,
   input  logic              prefixed,
   input  logic [DATA_W-1:0] x_low,
   input  logic [DATA_W-1:0] u_low,
   input  nzv_t              base,
   input  logic [CC_W-1:0]   cc_in,
   output logic [CC_W-1:0]   cc_out,
   output logic              vld
);

   localparam logic [CC_W-1:0] NEW_MASK =
      (CC_W'(1) << N_BIT) | (CC_W'(1) << Z_BIT) | (CC_W'(1) << V_BIT);
   localparam logic [CC_W-1:0] KEEP_MASK = ~NEW_MASK;

   if (N_BIT == Z_BIT || N_BIT == V_BIT || Z_BIT == V_BIT)
      $error("sti_merge: flag positions must differ");
   if (N_BIT >= CC_W || Z_BIT >= CC_W || V_BIT >= CC_W)
      $error("sti_merge: flag position outside condition byte");

   nzv_t            final_nzv;
   logic [CC_W-1:0] cc_next;
   logic            z_kill;

   always_comb begin
      unique case (sel_e'(sel))
         SEL_XY:  z_kill = (x_low != '0);
         SEL_US:  z_kill = (u_low != '0);
         default: z_kill = 1'b0;
      endcase
   end

   always_comb begin
      if (prefixed) begin
         final_nzv = NZV_FIXED;
      end else begin
         final_nzv   = base;
         final_nzv.z = base.z && !z_kill;
      end
   end

   always_comb begin
      cc_next        = cc_in;
      cc_next[N_BIT] = final_nzv.n;
      cc_next[Z_BIT] = final_nzv.z;
      cc_next[V_BIT] = final_nzv.v;
   end

   if (OUT_REG) begin : g_reg
      logic [CC_W-1:0] cc_q;
      logic            vld_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cc_q  <= '0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= req;
            if (req) cc_q <= cc_next;
         end
      end

      assign cc_out = cc_q;
      assign vld    = vld_q;

      // R9: prefixed store yields the fixed pattern
      p_prefix_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (req && prefixed) |=> (cc_q[N_BIT] && !cc_q[Z_BIT] && !cc_q[V_BIT]));

      // R8: non-zero X low byte kills Z on the X/Y form
      p_zkill_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (req && !prefixed && sel == SEL_XY && x_low != '0) |=> !cc_q[Z_BIT]);

      // R10: untouched bits follow the sampled input
      p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
         req |=> ((cc_q & KEEP_MASK) == ($past(cc_in) & KEEP_MASK)));

      // R11: valid only after a request
      p_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !req |=> !vld_q);
   end else begin : g_comb
      assign cc_out = req ? cc_next : '0;
      assign vld    = req;
   end

endmodule

// File: rtl/sti_flag_predict.sv
module sti_flag_predict
   import sti_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int CC_W    = 8,
   parameter int N_BIT   = 3,
   parameter int Z_BIT   = 2,
   parameter int V_BIT   = 1,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                retire_vld,
   input  logic [GRP_W-1:0]    retire_grp,
   input  logic [DATA_W-1:0]   alu_res_hi,
   input  logic [2*DATA_W-1:0] ea_value,
   input  logic [DATA_W-1:0]   acc_a,
   input  logic [DATA_W-1:0]   acc_b,
   input  logic [DATA_W-1:0]   x_low,
   input  logic [DATA_W-1:0]   u_low,
   input  logic                sti_req,
   input  logic [SEL_W-1:0]    sti_sel,
   input  logic                sti_prefixed,
   input  logic [CC_W-1:0]     cc_in,
   output logic [CC_W-1:0]     cc_out,
   output logic                cc_vld
);

   if (DATA_W < 2) $error("sti_flag_predict: DATA_W too small");

   grp_e              grp_q;
   logic [DATA_W-1:0] res_q;
   logic [DATA_W-1:0] addr_q;
   nzv_t              base_nzv;

   sti_grp_track #(.DATA_W(DATA_W)) i_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .retire_vld (retire_vld),
      .retire_grp (retire_grp),
      .alu_res_hi (alu_res_hi),
      .ea_value   (ea_value),
      .grp_q      (grp_q),
      .res_q      (res_q),
      .addr_q     (addr_q)
   );

   sti_rule_eval #(.DATA_W(DATA_W)) i_rule (
      .grp     (grp_q),
      .acc_a   (acc_a),
      .acc_b   (acc_b),
      .res_hi  (res_q),
      .addr_or (addr_q),
      .nzv     (base_nzv)
   );

   sti_merge #(
      .DATA_W (DATA_W),
      .CC_W   (CC_W),
      .N_BIT  (N_BIT),
      .Z_BIT  (Z_BIT),
      .V_BIT  (V_BIT),
      .OUT_REG(OUT_REG)
   ) i_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (sti_req),
      .sel      (sti_sel),
      .prefixed (sti_prefixed),
      .x_low    (x_low),
      .u_low    (u_low),
      .base     (base_nzv),
      .cc_in    (cc_in),
      .cc_out   (cc_out),
      .vld      (cc_vld)
   );

endmodule

// File: tb/test_sti_flag_predict.sv
module test_sti_flag_predict;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire_vld = 1'b0;
   logic [2:0]  retire_grp = '0;
   logic [7:0]  alu_res_hi = '0;
   logic [15:0] ea_value = '0;
   logic [7:0]  acc_a = '0, acc_b = '0, x_low = '0, u_low = '0;
   logic        sti_req = 1'b0;
   logic [1:0]  sti_sel = '0;
   logic        sti_prefixed = 1'b0;
   logic [7:0]  cc_in = '0;
   logic [7:0]  cc_out;
   logic        cc_vld;

   always #5 clk = ~clk;

   sti_flag_predict i_sti_flag_predict (
      .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_grp(retire_grp),
      .alu_res_hi(alu_res_hi), .ea_value(ea_value), .acc_a(acc_a), .acc_b(acc_b),
      .x_low(x_low), .u_low(u_low), .sti_req(sti_req), .sti_sel(sti_sel),
      .sti_prefixed(sti_prefixed), .cc_in(cc_in), .cc_out(cc_out), .cc_vld(cc_vld)
   );

   typedef struct {
      logic [7:0] cc;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 1'b0;

   // model state
   int         m_grp = 0;
   logic [7:0] m_res = '0;
   logic [7:0] m_addr = '0;

   function automatic logic [7:0] model(input int grp, input logic [7:0] a, b, rh, ad,
                                        input int sel, input logic [7:0] xl, ul,
                                        input bit pre, input logic [7:0] cin);
      logic n, z, v;
      logic [7:0] r, rm;
      logic [7:0] o;
      n = 1'b1; z = 1'b0; v = 1'b0;
      r = a;
      if (grp == 5) r = b;
      if (grp == 6) r = rh;
      if (grp == 7) r = ad;
      rm = r - 8'd1;
      case (grp)
         1: begin n = 0; z = 1; v = 0; end
         2: begin n = a[7]; z = (a == 8'h00); v = 0; end
         3: begin n = ~a[7]; z = (a == 8'hFF); v = 0; end
         4, 5, 6, 7: begin n = rm[7]; z = (r == 8'h01); v = (r == 8'h80); end
         default: begin n = 1; z = 0; v = 0; end
      endcase
      if (!pre && sel == 2 && xl != 0) z = 0;
      if (!pre && sel == 3 && ul != 0) z = 0;
      if (pre) begin n = 1; z = 0; v = 0; end
      o = cin;
      o[3] = n; o[2] = z; o[1] = v;
      return o;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_errors++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp_v);
      end
   endtask

   task automatic retire_set(input int grp, input logic [7:0] rh, input logic [15:0] ea);
      retire_vld = 1'b1;
      retire_grp = 3'(grp);
      alu_res_hi = rh;
      ea_value   = ea;
      m_grp  = grp;
      m_res  = rh;
      m_addr = ea[15:8] | ea[7:0];
   endtask

   task automatic req_set(input string tag, input int sel, input bit pre, input logic [7:0] cin);
      exp_t e;
      sti_req = 1'b1;
      sti_sel = 2'(sel);
      sti_prefixed = pre;
      cc_in = cin;
      e.cc  = model(m_grp, acc_a, acc_b, m_res, m_addr, sel, x_low, u_low, pre, cin);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic tick();
      @(negedge clk);
      retire_vld = 1'b0;
      sti_req    = 1'b0;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && cc_vld) begin
            if (exp_q.size() == 0) begin
               check("R11 unexpected valid", 8'h01, 8'h00);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(e.tag, cc_out, e.cc);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset cc_out", cc_out, 8'h00);
      check("R11 reset valid", {7'd0, cc_vld}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 default group after reset, R10 passthrough
      acc_a = 8'h01;
      req_set("R1 R10 default after reset", 0, 0, 8'hF5);
      tick();
      // R2 group without strobe is ignored
      retire_grp = 3'd1;
      req_set("R2 no strobe keeps group", 1, 0, 8'h0E);
      tick();
      @(negedge clk);
      check("R11 valid low when idle", {7'd0, cc_vld}, 8'h00);

      // R3
      retire_set(1, 8'h00, 16'h0000); tick();
      req_set("R3 compare group", 0, 0, 8'hA1); tick();

      // R4
      retire_set(2, 8'h00, 16'h0000); tick();
      acc_a = 8'h00; req_set("R4 load A zero", 0, 0, 8'h00); tick();
      acc_a = 8'h80; req_set("R4 load A negative", 0, 0, 8'hFF); tick();
      acc_a = 8'h35; req_set("R4 load A plain", 1, 0, 8'h00); tick();

      // R5
      retire_set(3, 8'h00, 16'h0000); tick();
      acc_a = 8'hFF; req_set("R5 alu A ff", 0, 0, 8'h00); tick();
      acc_a = 8'h00; req_set("R5 alu A zero", 0, 0, 8'h00); tick();
      acc_a = 8'h80; req_set("R5 alu A 80", 0, 0, 8'h00); tick();

      // R6 unary on A
      retire_set(4, 8'h00, 16'h0000); tick();
      acc_a = 8'h01; req_set("R6 unary A 01", 0, 0, 8'h00); tick();
      acc_a = 8'h80; req_set("R6 unary A 80", 0, 0, 8'h00); tick();
      acc_a = 8'h00; req_set("R6 unary A 00", 0, 0, 8'h00); tick();
      // R6 sign-extend on B
      retire_set(5, 8'h00, 16'h0000); tick();
      acc_a = 8'h01; acc_b = 8'h80; req_set("R6 sex B 80", 1, 0, 8'h00); tick();
      acc_b = 8'h01; req_set("R6 sex B 01", 0, 0, 8'h00); tick();

      // R7 compare16 snapshot
      retire_set(6, 8'h01, 16'h0000); tick();
      alu_res_hi = 8'h80;
      req_set("R7 cmp16 captured 01", 0, 0, 8'h00); tick();
      retire_set(6, 8'h80, 16'h0000); tick();
      req_set("R7 cmp16 captured 80", 0, 0, 8'h00); tick();
      // R7 address fold
      retire_set(7, 8'h00, 16'h0001); tick();
      ea_value = 16'h8000;
      req_set("R7 addr fold 01", 0, 0, 8'h00); tick();
      retire_set(7, 8'h00, 16'h8000); tick();
      req_set("R7 addr fold 80", 0, 0, 8'h00); tick();
      retire_set(7, 8'h00, 16'h0100); tick();
      req_set("R7 addr fold high 01", 0, 0, 8'h00); tick();

      // R8 Z override on 16-bit forms
      retire_set(1, 8'h00, 16'h0000); tick();
      x_low = 8'h10; u_low = 8'h00;
      req_set("R8 X low nonzero", 2, 0, 8'h00); tick();
      req_set("R8 U low zero", 3, 0, 8'h00); tick();
      x_low = 8'h00; u_low = 8'h42;
      req_set("R8 X low zero", 2, 0, 8'h00); tick();
      req_set("R8 U low nonzero", 3, 0, 8'h00); tick();
      req_set("R8 8-bit B ignores U", 1, 0, 8'h00); tick();

      // R9 prefix
      req_set("R9 prefixed over compare", 0, 1, 8'h5A); tick();
      x_low = 8'h00;
      req_set("R9 prefixed 16-bit", 2, 1, 8'hC0); tick();

      // R2 same-cycle retire and request
      req_set("R2 same cycle uses old group", 0, 0, 8'h33);
      retire_set(0, 8'h00, 16'h0000);
      tick();
      req_set("R2 new group after retire", 0, 0, 8'h33); tick();

      // R10 passthrough of all other bits
      req_set("R10 passthrough ones", 1, 0, 8'hFF); tick();
      req_set("R10 passthrough zeros", 1, 0, 8'h00); tick();

      repeat (3) @(negedge clk);
      check("R11 all results delivered", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule